// File: doc/BRIEF.md
# Concurrent Write Conflict Resolver

This block is the write side of a small shared register file used by a group of lock-stepped processing elements (PEs). In every step each PE may issue a write (a valid bit, a location address and a data word) and a read. When two or more PEs aim at the same location in the same step, a run-time policy settles what gets stored. The policy can reject the collision, let one writer win by a fixed rule or by a reproducible pseudo-random draw, demand that all writers agree, or merge all colliding words with an arithmetic or logic operator.

A step has three phases. The read phase samples the file. The resolution logic then decides the outcome. The write phase updates the file at the clock edge. A read therefore always returns the contents from before that step's writes. For every location the block registers a conflict flag and a common-value failure flag. For every PE it registers an accepted bit. Collisions under the exclusive-write policy and same-location reads under exclusive-read checking each set their own sticky error bit.

Top module: `cw_resolver`

## Requirements
- R1: While rst_n is low (asynchronous, active low), every location, wr_ok, conflict, fail, rd_data, ew_err and er_err read 0, and the random-pick LFSR is loaded with the SEED parameter.
- R2: A location targeted by exactly one valid writer in a step stores that PE's word at the next clock edge under every policy. That PE's wr_ok bit is set and the location's conflict bit stays clear. Locations with no writer keep their value.
- R3: Policy code 0 (exclusive write): a location hit by two or more writers keeps its value, none of those writers is accepted, and ew_err rises and stays high until reset.
- R4: Policy code 1 (priority): among colliding writers the one with the highest PE index stores its word and is the only one accepted.
- R5: Policy code 2 (common value): if every colliding writer presents the same word, that word is stored and all of them are accepted. Otherwise the location is unchanged, none is accepted, and its fail bit is set for one cycle.
- R6: Policy code 3 (arbitrary): among colliding writers the one with the lowest PE index stores its word and is the only one accepted.
- R7: Policy code 4 (random): with L the 8-bit LFSR value and C the number of colliders, the writer at ordinal L mod C (counting colliders upward by PE index from 0) wins. The LFSR steps as {L[6:0], L[7]^L[5]^L[4]^L[3]} only at edges that end a random-policy step with at least one collision. All locations in that step use the same L.
- R8: Policy code 5 (numeric merge): the stored word is the unsigned merge of all colliding words, with op 0 giving the sum mod 2^DW, 1 the product mod 2^DW, 2 the maximum and 3 the minimum. All colliders are accepted.
- R9: Policy code 6 (logic merge): the stored word is the bitwise AND (op 0), OR (op 1) or XOR (op 2 or 3) of all colliding words. All colliders are accepted.
- R10: Under every policy, conflict bit l is set for one cycle exactly when two or more valid writers targeted location l in the previous step.
- R11: For each valid reader, rd_data returns at the next edge the word the location held before that step's writes.
- R12: When er_en is high and two or more valid readers address the same location, er_err rises and stays high until reset. The reads are still served. With er_en low no read pattern sets er_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Collision policy code (0..6) |
| op | input | 2 | Merge operator select for codes 5 and 6 |
| er_en | input | 1 | Enable exclusive-read checking |
| wr_vld | input | NPE | Write request per PE |
| wr_addr | input | NPE*AW | Write location, PE p in bits [p*AW +: AW] |
| wr_data | input | NPE*DW | Write word, PE p in bits [p*DW +: DW] |
| rd_vld | input | NPE | Read request per PE |
| rd_addr | input | NPE*AW | Read location, PE p in bits [p*AW +: AW] |
| rd_data | output | NPE*DW | Registered read word, PE p in bits [p*DW +: DW] |
| mem_q | output | NLOC*DW | Register file contents, location l in bits [l*DW +: DW] |
| wr_ok | output | NPE | Per-PE write accepted in the last step |
| conflict | output | NLOC | Per-location collision seen in the last step |
| fail | output | NLOC | Per-location common-value mismatch in the last step |
| ew_err | output | 1 | Sticky exclusive-write violation |
| er_err | output | 1 | Sticky exclusive-read violation |

## Verification
The random policy is the hardest case to predict from the ports, because the winner depends on an LFSR state that only moves on random-policy collision steps. The bench resets to a known seed and keeps its own copy of the register. It steps that copy only on the steps that should advance it, including one random-policy step with a lone writer that must not advance it. It then drives collisions of different sizes, so that the modulo pick lands on several distinct writers.

// File: rtl/cw_resolver.sv
module cw_resolver #(
  parameter int NPE = 4,
  parameter int AW = 2,
  parameter int DW = 8,
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                mode,
  input  logic [1:0]                op,
  input  logic                      er_en,
  input  logic [NPE-1:0]            wr_vld,
  input  logic [NPE*AW-1:0]         wr_addr,
  input  logic [NPE*DW-1:0]         wr_data,
  input  logic [NPE-1:0]            rd_vld,
  input  logic [NPE*AW-1:0]         rd_addr,
  output logic [NPE*DW-1:0]         rd_data,
  output logic [(1<<AW)*DW-1:0]     mem_q,
  output logic [NPE-1:0]            wr_ok,
  output logic [(1<<AW)-1:0]        conflict,
  output logic [(1<<AW)-1:0]        fail,
  output logic                      ew_err,
  output logic                      er_err
);
  localparam int NLOC = 1 << AW;
  localparam logic [2:0] M_PRIO = 3'd1, M_COMMON = 3'd2, M_ARB = 3'd3,
                         M_RAND = 3'd4, M_NUM = 3'd5, M_BOOL = 3'd6;

  logic [DW-1:0]   mem   [NLOC];
  logic [DW-1:0]   mem_n [NLOC];
  logic [DW-1:0]   wd    [NPE];
  logic [NPE-1:0]  hits  [NLOC];
  logic [NPE-1:0]  acc_n;
  logic [NLOC-1:0] conf_n, fail_n;
  logic            ew_n, er_n, rnd_n;
  logic [7:0]      lfsr;
  logic [DW-1:0]   val;
  logic            agree;
  int              cnt, lo, hi, pick, j, k, rc;

  for (genvar g = 0; g < NPE; g++) begin : g_pe
    assign wd[g] = wr_data[g*DW +: DW];
  end
  for (genvar g = 0; g < NLOC; g++) begin : g_loc
    assign mem_q[g*DW +: DW] = mem[g];
  end

  always_comb begin
    for (int l = 0; l < NLOC; l++)
      for (int p = 0; p < NPE; p++)
        hits[l][p] = wr_vld[p] && (wr_addr[p*AW +: AW] == AW'(l));
  end

  always_comb begin
    er_n = 1'b0;
    rc = 0;
    for (int l = 0; l < NLOC; l++) begin
      rc = 0;
      for (int p = 0; p < NPE; p++)
        if (rd_vld[p] && rd_addr[p*AW +: AW] == AW'(l)) rc++;
      if (er_en && rc > 1) er_n = 1'b1;
    end
  end

  always_comb begin
    acc_n = '0; conf_n = '0; fail_n = '0;
    ew_n = 1'b0; rnd_n = 1'b0;
    cnt = 0; lo = 0; hi = 0; pick = 0; j = 0; k = 0;
    agree = 1'b1; val = '0;
    for (int l = 0; l < NLOC; l++) mem_n[l] = mem[l];
    for (int l = 0; l < NLOC; l++) begin
      cnt = 0; lo = 0; hi = 0;
      for (int p = NPE-1; p >= 0; p--)
        if (hits[l][p]) begin cnt++; lo = p; end
      for (int p = 0; p < NPE; p++)
        if (hits[l][p]) hi = p;
      if (cnt == 1) begin
        mem_n[l] = wd[lo];
        acc_n[lo] = 1'b1;
      end else if (cnt > 1) begin
        conf_n[l] = 1'b1;
        case (mode)
          M_PRIO: begin
            mem_n[l] = wd[hi];
            acc_n[hi] = 1'b1;
          end
          M_ARB: begin
            mem_n[l] = wd[lo];
            acc_n[lo] = 1'b1;
          end
          M_COMMON: begin
            agree = 1'b1;
            for (int p = 0; p < NPE; p++)
              if (hits[l][p] && wd[p] != wd[lo]) agree = 1'b0;
            if (agree) begin
              mem_n[l] = wd[lo];
              acc_n = acc_n | hits[l];
            end else begin
              fail_n[l] = 1'b1;
            end
          end
          M_RAND: begin
            rnd_n = 1'b1;
            k = int'(lfsr) % cnt;
            j = 0;
            pick = lo;
            for (int p = 0; p < NPE; p++)
              if (hits[l][p]) begin
                if (j == k) pick = p;
                j++;
              end
            mem_n[l] = wd[pick];
            acc_n[pick] = 1'b1;
          end
          M_NUM: begin
            val = wd[lo];
            for (int p = 0; p < NPE; p++)
              if (hits[l][p] && p != lo) begin
                case (op)
                  2'd0: val = val + wd[p];
                  2'd1: val = val * wd[p];
                  2'd2: if (wd[p] > val) val = wd[p];
                  default: if (wd[p] < val) val = wd[p];
                endcase
              end
            mem_n[l] = val;
            acc_n = acc_n | hits[l];
          end
          M_BOOL: begin
            val = wd[lo];
            for (int p = 0; p < NPE; p++)
              if (hits[l][p] && p != lo) begin
                if (op[1])      val = val ^ wd[p];
                else if (op[0]) val = val | wd[p];
                else            val = val & wd[p];
              end
            mem_n[l] = val;
            acc_n = acc_n | hits[l];
          end
          default: ew_n = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLOC; l++) mem[l] <= '0;
      rd_data  <= '0;
      wr_ok    <= '0;
      conflict <= '0;
      fail     <= '0;
      ew_err   <= 1'b0;
      er_err   <= 1'b0;
      lfsr     <= SEED;
    end else begin
      for (int l = 0; l < NLOC; l++) mem[l] <= mem_n[l];
      for (int p = 0; p < NPE; p++)
        if (rd_vld[p]) rd_data[p*DW +: DW] <= mem[rd_addr[p*AW +: AW]];
      wr_ok    <= acc_n;
      conflict <= conf_n;
      fail     <= fail_n;
      ew_err   <= ew_err | ew_n;
      er_err   <= er_err | er_n;
      if (rnd_n) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  end
endmodule

// File: rtl/cw_resolver_chk.sv
module cw_resolver_chk #(
  parameter int NPE = 4,
  parameter int AW = 2,
  parameter int DW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPE-1:0]        wr_vld,
  input logic [NPE-1:0]        wr_ok,
  input logic [(1<<AW)-1:0]    conflict,
  input logic [(1<<AW)-1:0]    fail,
  input logic                  ew_err,
  input logic                  er_err,
  input logic [(1<<AW)*DW-1:0] mem_q
);
  localparam int NLOC = 1 << AW;

  assert_ew_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ew_err |=> ew_err);

  assert_er_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    er_err |=> er_err);

  assert_ok_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok & ~$past(wr_vld)) == '0);

  assert_fail_within_conflict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail & ~conflict) == '0);

  for (genvar g = 0; g < NLOC; g++) begin : g_hold
    assert_fail_keeps_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fail[g] |-> mem_q[g*DW +: DW] == $past(mem_q[g*DW +: DW]));
  end
endmodule

bind cw_resolver cw_resolver_chk #(.NPE(NPE), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_ok(wr_ok),
  .conflict(conflict), .fail(fail), .ew_err(ew_err), .er_err(er_err),
  .mem_q(mem_q)
);

// File: tb/tb_cw_resolver.sv
module tb_cw_resolver;
  localparam int NPE = 4, AW = 2, DW = 8;
  localparam logic [7:0] SEED = 8'hA5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  op = '0;
  logic        er_en = 1'b0;
  logic [3:0]  wr_vld = '0, rd_vld = '0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, mem_q;
  logic [3:0]  wr_ok, conflict, fail;
  logic        ew_err, er_err;
  logic [7:0]  lfsr_m;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  cw_resolver #(.NPE(NPE), .AW(AW), .DW(DW), .SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .op(op), .er_en(er_en),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_vld(rd_vld), .rd_addr(rd_addr), .rd_data(rd_data),
    .mem_q(mem_q), .wr_ok(wr_ok), .conflict(conflict), .fail(fail),
    .ew_err(ew_err), .er_err(er_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] loc(input int l);
    return mem_q[l*8 +: 8];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; wr_vld = '0; rd_vld = '0; er_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    lfsr_m = SEED;
  endtask

  task automatic step(input logic [2:0] m, input logic [1:0] o, input logic [3:0] v,
                      input logic [7:0] a, input logic [31:0] d);
    mode = m; op = o; wr_vld = v; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_vld = '0; rd_vld = '0;
  endtask

  function automatic logic [7:0] lfsr_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    chk("R1 mem", mem_q, 32'h0);
    chk("R1 flags", {wr_ok, conflict, fail, 2'b00, ew_err, er_err}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    do_reset();
  endtask

  task automatic t_single();
    step(3'd0, 2'd0, 4'b1111, {2'd3, 2'd2, 2'd1, 2'd0}, 32'h44332211);
    chk("R2 stored", mem_q, 32'h44332211);
    chk("R2 accepted", wr_ok, 4'b1111);
    chk("R10 no conflict", conflict, 4'b0000);
    step(3'd5, 2'd1, 4'b0100, {2'd0, 2'd1, 2'd0, 2'd0}, 32'h00550000);
    chk("R2 lone writer in merge mode", mem_q, 32'h44335511);
  endtask

  task automatic t_excl();
    step(3'd0, 2'd0, 4'b1101, {2'd3, 2'd1, 2'd0, 2'd1}, 32'h99880077);
    chk("R3 location kept", loc(1), 8'h55);
    chk("R3 other location", loc(3), 8'h99);
    chk("R3 accepted", wr_ok, 4'b1000);
    chk("R10 conflict loc1", conflict, 4'b0010);
    chk("R3 ew_err set", ew_err, 1'b1);
    step(3'd0, 2'd0, 4'b0000, 8'h0, 32'h0);
    chk("R3 ew_err sticky", ew_err, 1'b1);
    chk("R10 conflict clears", conflict, 4'b0000);
    do_reset();
  endtask

  task automatic t_prio_arb();
    step(3'd1, 2'd0, 4'b1111, 8'h00, 32'h04030201);
    chk("R4 highest index wins", loc(0), 8'h04);
    chk("R4 accepted", wr_ok, 4'b1000);
    chk("R10 priority conflict", conflict, 4'b0001);
    step(3'd3, 2'd0, 4'b1110, {2'd2, 2'd2, 2'd2, 2'd0}, 32'h07060500);
    chk("R6 lowest index wins", loc(2), 8'h05);
    chk("R6 accepted", wr_ok, 4'b0010);
    chk("R3 no error outside code 0", ew_err, 1'b0);
  endtask

  task automatic t_common();
    step(3'd2, 2'd0, 4'b0011, {2'd0, 2'd0, 2'd3, 2'd3}, 32'h00003C3C);
    chk("R5 agree stored", loc(3), 8'h3C);
    chk("R5 agree accepted", wr_ok, 4'b0011);
    chk("R5 agree no fail", fail, 4'b0000);
    step(3'd2, 2'd0, 4'b1100, {2'd3, 2'd3, 2'd0, 2'd0}, 32'h20100000);
    chk("R5 mismatch kept", loc(3), 8'h3C);
    chk("R5 mismatch fail", fail, 4'b1000);
    chk("R5 mismatch none accepted", wr_ok, 4'b0000);
    chk("R10 common conflict", conflict, 4'b1000);
  endtask

  task automatic t_merge();
    step(3'd5, 2'd0, 4'b1111, {2'd1, 2'd1, 2'd1, 2'd1}, {8'd250, 8'd30, 8'd20, 8'd10});
    chk("R8 sum wraps", loc(1), 8'd54);
    chk("R8 all accepted", wr_ok, 4'b1111);
    step(3'd5, 2'd1, 4'b0111, {2'd0, 2'd1, 2'd1, 2'd1}, {8'd0, 8'd7, 8'd5, 8'd3});
    chk("R8 product", loc(1), 8'd105);
    step(3'd5, 2'd2, 4'b1011, {2'd1, 2'd0, 2'd1, 2'd1}, {8'd17, 8'd0, 8'd200, 8'd9});
    chk("R8 max", loc(1), 8'd200);
    step(3'd5, 2'd3, 4'b1011, {2'd1, 2'd0, 2'd1, 2'd1}, {8'd17, 8'd0, 8'd200, 8'd9});
    chk("R8 min", loc(1), 8'd9);
    step(3'd6, 2'd0, 4'b0111, {2'd0, 2'd2, 2'd2, 2'd2}, 32'h00FF3CF0);
    chk("R9 and", loc(2), 8'h30);
    step(3'd6, 2'd1, 4'b1101, {2'd2, 2'd2, 2'd0, 2'd2}, 32'h80020001);
    chk("R9 or", loc(2), 8'h83);
    step(3'd6, 2'd2, 4'b0111, {2'd0, 2'd2, 2'd2, 2'd2}, 32'h00FF3CF0);
    chk("R9 xor", loc(2), 8'h33);
    chk("R9 accepted", wr_ok, 4'b0111);
  endtask

  task automatic t_random();
    int k, ord;
    int pk;
    do_reset();
    step(3'd4, 2'd0, 4'b0001, 8'h00, 32'h000000EE);
    chk("R7 lone writer stored", loc(0), 8'hEE);
    for (int it = 0; it < 4; it++) begin
      k = int'(lfsr_m) % 4;
      step(3'd4, 2'd0, 4'b1111, 8'h00, 32'hA3A2A1A0);
      chk("R7 pick of four", loc(0), 8'hA0 + 8'(k));
      chk("R7 one accepted", wr_ok, 4'b0001 << k);
      lfsr_m = lfsr_next(lfsr_m);
    end
    for (int it = 0; it < 3; it++) begin
      k = int'(lfsr_m) % 3;
      ord = 0; pk = 0;
      for (int p = 0; p < 4; p++)
        if (p != 2) begin
          if (ord == k) pk = p;
          ord++;
        end
      step(3'd4, 2'd0, 4'b1011, 8'h55, 32'hB3B2B1B0);
      chk("R7 pick of three", loc(1), 8'hB0 + 8'(pk));
      lfsr_m = lfsr_next(lfsr_m);
    end
  endtask

  task automatic t_read();
    do_reset();
    step(3'd0, 2'd0, 4'b0001, 8'h00, 32'h00000011);
    rd_vld = 4'b0001; rd_addr = 8'h00;
    step(3'd0, 2'd0, 4'b0010, 8'h00, 32'h00002200);
    chk("R11 read sees old word", rd_data[7:0], 8'h11);
    chk("R11 write landed", loc(0), 8'h22);
    rd_vld = 4'b0001; rd_addr = 8'h00;
    step(3'd0, 2'd0, 4'b0000, 8'h00, 32'h0);
    chk("R11 read sees new word", rd_data[7:0], 8'h22);
    er_en = 1'b0; rd_vld = 4'b0011; rd_addr = {2'd0, 2'd0, 2'd2, 2'd2};
    step(3'd0, 2'd0, 4'b0000, 8'h00, 32'h0);
    chk("R12 disabled no error", er_err, 1'b0);
    er_en = 1'b1; rd_vld = 4'b0011; rd_addr = {2'd0, 2'd0, 2'd1, 2'd0};
    step(3'd0, 2'd0, 4'b0000, 8'h00, 32'h0);
    chk("R12 distinct no error", er_err, 1'b0);
    rd_vld = 4'b1100; rd_addr = {2'd0, 2'd0, 2'd1, 2'd0};
    step(3'd0, 2'd0, 4'b0000, 8'h00, 32'h0);
    chk("R12 shared read error", er_err, 1'b1);
    chk("R12 read still served", rd_data[31:24], 8'h22);
    er_en = 1'b0;
    step(3'd0, 2'd0, 4'b0000, 8'h00, 32'h0);
    chk("R12 error sticky", er_err, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_single();
        t_excl();
        t_prio_arb();
        t_common();
        t_merge();
        t_random();
        t_read();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule